// File: doc/BRIEF.md
# Two's Complement Negate and Absolute-Value Unit

This block is a purely combinational datapath element that takes one signed operand in two's complement form and, depending on a one-bit operation select, returns either the arithmetic negative of the operand or its magnitude. Negation is formed by flipping every operand bit and then adding one through a ripple incrementer; whatever carry leaves the top bit is dropped, so the result always has the operand's width.

Alongside the result word the block raises an overflow flag. Only one operand code can trigger it: the most negative value, whose positive counterpart does not fit in the width. For that code both operations return the operand unchanged, still negative, and the flag tells the consumer not to trust the sign. The flag is derived from the incrementer itself: a carry arrives at the sign position but none leaves it. Typical users are an ALU's operand conditioning stage or a sign-magnitude conversion step ahead of an unsigned multiplier.

Top module: `tc_negabs`

## Requirements
- R1: With the select at 0 (negate), every operand other than zero and the most negative code yields a result that, added to the operand modulo 2^WIDTH, gives zero, with the overflow flag low.
- R2: Negating zero yields zero with the overflow flag low; the carry produced past the top bit is discarded.
- R3: Negating the most negative code (sign bit 1, all other bits 0) returns that same code with the overflow flag high.
- R4: With the select at 1 (absolute value), an operand whose sign bit (bit WIDTH-1) is 0 appears unchanged on the result with the overflow flag low.
- R5: In absolute-value mode, a negative operand other than the most negative code yields its magnitude, a result with sign bit 0, and the overflow flag low.
- R6: In absolute-value mode, the most negative code is returned unchanged (still negative) with the overflow flag high.
- R7: The overflow flag is high only when the operand is the most negative code, in either mode, and low for all other operand codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | WIDTH | Signed two's complement operand |
| op_i | input | 1 | Operation select: 0 negate, 1 absolute value |
| result_o | output | WIDTH | Negated or absolute value, same width as the operand |
| ovf_o | output | 1 | High when the true result cannot be represented |

## Verification
The hard corner is the single operand whose negation folds back onto itself: one code out of 2^WIDTH, reachable in two modes, and easy to miss with random stimulus. The bench therefore sweeps every operand code at the default width in both select settings, which places the most negative code, zero, the value one above the minimum and the largest positive code each in front of the scoreboard in both modes, and it repeats the folding code back to back with a mode flip so that the flag must hold across a select change.

// File: rtl/tc_negabs_pkg.sv
package tc_negabs_pkg;

    // Operation select encoding.
    typedef enum logic {
        OP_NEG = 1'b0,
        OP_ABS = 1'b1
    } tc_op_e;

    // Carries seen at the sign position of the incrementer.
    typedef struct packed {
        logic into_sign;
        logic out_of_sign;
    } tc_sign_carry_t;

    // Result bundle leaving the mode selector (flag part only; the
    // word itself is width dependent and travels as a plain vector).
    typedef struct packed {
        logic use_negated;
        logic overflow;
    } tc_decision_t;

    localparam int unsigned TC_DEFAULT_WIDTH = 8;

    // A carry that enters the sign bit without leaving it marks the
    // one unrepresentable negation.
    function automatic logic sign_carry_mismatch(input tc_sign_carry_t c);
        return c.into_sign ^ c.out_of_sign;
    endfunction

endpackage

// File: rtl/tc_negator.sv
module tc_negator
    import tc_negabs_pkg::*;
#(
    parameter int unsigned WIDTH = TC_DEFAULT_WIDTH
) (
    input  logic [WIDTH-1:0] opnd_i,
    output logic [WIDTH-1:0] neg_o,
    output tc_sign_carry_t   carry_o
);

    localparam int unsigned TOP = WIDTH - 1;

    logic [WIDTH-1:0] flipped;

    // Bitwise complement, one gate per bit.
    for (genvar b = 0; b < WIDTH; b++) begin : g_flip
        assign flipped[b] = ~opnd_i[b];
    end

    // Ripple incrementer adding one to the complement; the final carry
    // is reported but never widens the word.
    always_comb begin
        logic ripple;
        ripple            = 1'b1;
        neg_o             = '0;
        carry_o.into_sign = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            neg_o[i] = flipped[i] ^ ripple;
            if (i == TOP) begin
                carry_o.into_sign = ripple;
            end
            ripple = flipped[i] & ripple;
        end
        carry_o.out_of_sign = ripple;
    end

endmodule

// File: rtl/tc_mode_sel.sv
module tc_mode_sel
    import tc_negabs_pkg::*;
#(
    parameter int unsigned WIDTH = TC_DEFAULT_WIDTH
) (
    input  tc_op_e           op_i,
    input  logic             sign_i,
    input  tc_sign_carry_t   carry_i,
    output tc_decision_t     dec_o
);

    always_comb begin
        unique case (op_i)
            OP_NEG:  dec_o.use_negated = 1'b1;
            OP_ABS:  dec_o.use_negated = sign_i;
            default: dec_o.use_negated = 1'b1;
        endcase
        // Overflow only matters when the negated word is the one chosen.
        dec_o.overflow = dec_o.use_negated & sign_carry_mismatch(carry_i);
    end

endmodule

// File: rtl/tc_negabs.sv
module tc_negabs
    import tc_negabs_pkg::*;
#(
    parameter int unsigned WIDTH = TC_DEFAULT_WIDTH
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic             op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             ovf_o
);

    localparam int unsigned SIGN_POS = WIDTH - 1;

    logic [WIDTH-1:0] negated;
    tc_sign_carry_t   carries;
    tc_decision_t     decision;

    tc_negator #(.WIDTH(WIDTH)) u_negator (
        .opnd_i  (opnd_i),
        .neg_o   (negated),
        .carry_o (carries)
    );

    tc_mode_sel #(.WIDTH(WIDTH)) u_mode_sel (
        .op_i    (tc_op_e'(op_i)),
        .sign_i  (opnd_i[SIGN_POS]),
        .carry_i (carries),
        .dec_o   (decision)
    );

    assign result_o = decision.use_negated ? negated : opnd_i;
    assign ovf_o    = decision.overflow;

endmodule

// File: rtl/tc_negabs_chk.sv
module tc_negabs_chk
    import tc_negabs_pkg::*;
#(
    parameter int unsigned WIDTH = TC_DEFAULT_WIDTH
) (
    input logic [WIDTH-1:0] opnd_i,
    input logic             op_i,
    input logic [WIDTH-1:0] result_o,
    input logic             ovf_o
);

    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    always_comb begin
        // R7: the flag points at the folding code only
        if (ovf_o) a_r7_ovf_only_min: assert (opnd_i == MOST_NEG);
        // R3: negating the folding code hands it back with the flag
        if (op_i == 1'b0 && opnd_i == MOST_NEG)
            a_r3_min_folds: assert (result_o == MOST_NEG && ovf_o);
        // R6: magnitude of the folding code stays negative, flagged
        if (op_i == 1'b1 && opnd_i == MOST_NEG)
            a_r6_abs_min_flagged: assert (result_o == MOST_NEG && ovf_o);
        // R2: zero maps to zero without overflow
        if (op_i == 1'b0 && opnd_i == '0)
            a_r2_zero_neg: assert (result_o == '0 && !ovf_o);
        // R1: result and operand cancel modulo 2^WIDTH
        if (op_i == 1'b0 && !ovf_o)
            a_r1_cancels: assert (WIDTH'(result_o + opnd_i) == '0);
        // R4: non-negative operands pass through in magnitude mode
        if (op_i == 1'b1 && !opnd_i[WIDTH-1])
            a_r4_abs_pass: assert (result_o == opnd_i && !ovf_o);
        // R5: unflagged magnitudes are non-negative
        if (op_i == 1'b1 && !ovf_o)
            a_r5_abs_sign_clear: assert (!result_o[WIDTH-1]);
    end

endmodule

bind tc_negabs tc_negabs_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_i   (opnd_i),
    .op_i     (op_i),
    .result_o (result_o),
    .ovf_o    (ovf_o)
);

// File: tb/tc_negabs_tb.sv
module tc_negabs_tb;

    localparam int W          = 8;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic [W-1:0] value;
        logic         ovf;
        logic [W-1:0] opnd;
        logic         op;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opnd = '0;
    logic         op = 1'b0;
    logic [W-1:0] result;
    logic         ovf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    exp_t sb[$];

    tc_negabs #(.WIDTH(W)) u_dut (
        .opnd_i   (opnd),
        .op_i     (op),
        .result_o (result),
        .ovf_o    (ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model built from the requirements.
    function automatic exp_t model(input logic [W-1:0] x, input logic m);
        exp_t e;
        int   sv;
        sv = x[W-1] ? int'(x) - (1 << W) : int'(x);
        e.opnd = x;
        e.op   = m;
        if (sv == -(1 << (W-1))) begin
            e.value = x;
            e.ovf   = 1'b1;
            e.req   = m ? "R6" : "R3";
        end else if (!m) begin
            e.value = W'(-sv);
            e.ovf   = 1'b0;
            e.req   = (sv == 0) ? "R2" : "R1";
        end else if (sv < 0) begin
            e.value = W'(-sv);
            e.ovf   = 1'b0;
            e.req   = "R5";
        end else begin
            e.value = x;
            e.ovf   = 1'b0;
            e.req   = "R4";
        end
        return e;
    endfunction

    task automatic drive(input logic [W-1:0] x, input logic m);
        @(posedge clk);
        #1;
        opnd = x;
        op   = m;
        sb.push_back(model(x, m));
    endtask

    // Monitor: compare mid-cycle, away from the driving edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (result !== e.value) begin
                    errors++;
                    $display("FAIL %s result op=%0b opnd=%h: got %h expected %h",
                             e.req, e.op, e.opnd, result, e.value);
                end
                checks++;
                // R7: flag raised only for the folding code
                if (ovf !== e.ovf) begin
                    errors++;
                    $display("FAIL R7/%s ovf op=%0b opnd=%h: got %0b expected %0b",
                             e.req, e.op, e.opnd, ovf, e.ovf);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        while (!done && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // Idle state check: zero operand in negate mode (R2).
        @(negedge clk);
        checks++;
        if (result !== '0 || ovf !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle: got %h/%0b expected 00/0", result, ovf);
        end
        // Exhaustive sweep, both modes (R1..R7).
        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < (1 << W); v++) begin
                drive(W'(v), m[0]);
            end
        end
        // Folding code with a select flip on consecutive cycles (R3, R6).
        drive({1'b1, {(W-1){1'b0}}}, 1'b0);
        drive({1'b1, {(W-1){1'b0}}}, 1'b1);
        drive({1'b1, {(W-1){1'b0}}}, 1'b0);
        // Neighbours of the folding code and extremes (R1, R4, R5).
        drive({1'b1, {(W-2){1'b0}}, 1'b1}, 1'b1);
        drive({1'b0, {(W-1){1'b1}}}, 1'b1);
        drive({1'b0, {(W-1){1'b1}}}, 1'b0);
        drive('1, 1'b1);
        drive('0, 1'b1);
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule